// File: doc/BRIEF.md
# Partitioned Message Slot Allocator

This block keeps the used/free state of a pool of message slots that incoming and outgoing traffic share. A receive-side request and a transmit-side request can each be raised in any cycle. Each request is answered in the same cycle with either a grant plus the index of the slot taken, or a failure flag. The slot is marked used at the clock edge that ends that cycle, so the test and the claim form one step. A free port returns a slot by index.

The two request ports search different ranges. Receive requests may take any slot. Transmit requests may only take slots from one quarter of the pool upward. Because of this, the bottom quarter stays available to incoming messages: a response can always be accepted, even when every transmit slot is held. When both ports request in the same cycle, the receive port is served first and the transmit port searches what is left. The block also reports how many slots are occupied, and it raises a sticky flag when a slot is freed while already free.

Top module: `msg_slot_alloc`

## Requirements
- R1: A receive request is granted the lowest-indexed free slot in the whole pool, indices 0 to SLOTS-1, in the same cycle as the request.
- R2: A transmit request is granted the lowest-indexed free slot with index at least SLOTS/4 (8 with the default of 32). It is never granted a slot below that floor, even when such a slot is free.
- R3: A granted slot is marked used from the next clock edge on, and no later request is granted it until it has been freed.
- R4: When no free slot exists in a port's allowed range, the request raises that port's fail output and its grant stays low. Without a request, neither grant nor fail is raised.
- R5: A free of a used slot clears its used bit only, so the slot is available again from the next cycle.
- R6: When both ports request in one cycle, the receive port takes its slot first. The transmit port gets the lowest remaining free slot in its range, which is never the slot just given to the receive port.
- R7: A free and a request that target the same slot in one cycle see that slot as free. The slot is granted and ends the cycle used.
- R8: The occupancy output equals the number of used slots. It is registered and changes at the clock edge that applies a grant or a free.
- R9: Freeing a slot that is already free sets the error output. The error output then stays high until reset, and the occupancy output is not changed by that free.
- R10: While reset is asserted, and after it is released, all slots are free and the occupancy and error outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_req_i | input | 1 | Receive-side allocation request |
| rx_gnt_o | output | 1 | Receive request granted this cycle |
| rx_fail_o | output | 1 | Receive request found no free slot |
| rx_idx_o | output | $clog2(SLOTS) | Slot granted to the receive port |
| tx_req_i | input | 1 | Transmit-side allocation request |
| tx_gnt_o | output | 1 | Transmit request granted this cycle |
| tx_fail_o | output | 1 | Transmit request found no free slot in its range |
| tx_idx_o | output | $clog2(SLOTS) | Slot granted to the transmit port |
| free_i | input | 1 | Return a slot to the pool |
| free_idx_i | input | $clog2(SLOTS) | Index of the slot being returned |
| occ_o | output | $clog2(SLOTS)+1 | Number of slots in use |
| err_o | output | 1 | Sticky flag: a free slot was freed |

## Verification
A vector table covers single receive and transmit requests, both ports at once, a free and a grant of the same slot in one cycle, a slot reused after a free, and a double free. Together these separate the lowest-free search order, the same-cycle free-before-claim rule, the receive-first ordering, and the error and occupancy bookkeeping. Directed sequences then fill the transmit range slot by slot until it fails while low slots are still free, which shows the floor is held. They next exhaust the whole pool so both ports fail, and finally free a low slot that only the receive port may take.

// File: rtl/msa_pkg.sv
package msa_pkg;
  localparam int unsigned MSA_DEF_SLOTS = 32;

  // first slot index usable by transmit traffic
  function automatic int unsigned msa_tx_floor(input int unsigned slots);
    return slots / 4;
  endfunction
endpackage

// File: rtl/msa_first_free.sv
module msa_first_free #(
  parameter int unsigned SLOTS = 32,
  parameter int unsigned BASE  = 0,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] avail_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [SLOTS-1:0] onehot_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    // descending scan: last match is the lowest index
    for (int i = int'(SLOTS) - 1; i >= int'(BASE); i--) begin
      if (avail_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
    onehot_o = hit_o ? (SLOTS'(1) << idx_o) : '0;
  end
endmodule

// File: rtl/msa_used_bank.sv
module msa_used_bank #(
  parameter int unsigned SLOTS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SLOTS-1:0] set_i,
  input  logic [SLOTS-1:0] clr_i,
  output logic [SLOTS-1:0] used_o
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       used_o[g] <= 1'b0;
      else if (set_i[g]) used_o[g] <= 1'b1;  // set wins over clear
      else if (clr_i[g]) used_o[g] <= 1'b0;
    end

    AST_SET_MARKS_USED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> used_o[g]);  // R3
  end
endmodule

// File: rtl/msa_free_check.sv
module msa_free_check #(
  parameter int unsigned SLOTS = 32,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             free_i,
  input  logic [IDX_W-1:0] free_idx_i,
  input  logic [SLOTS-1:0] used_i,
  output logic [SLOTS-1:0] clr_o,
  output logic             dec_o,
  output logic             err_o
);
  logic [SLOTS-1:0] sel;
  logic             dbl;

  assign sel   = free_i ? (SLOTS'(1) << free_idx_i) : '0;
  assign clr_o = sel & used_i;
  assign dec_o = |clr_o;
  assign dbl   = free_i & ~used_i[free_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  err_o <= 1'b0;
    else if (dbl) err_o <= 1'b1;
  end

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);  // R9
  AST_DBL_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_i && !used_i[free_idx_i]) |=> err_o);  // R9
endmodule

// File: rtl/msa_occ_counter.sv
module msa_occ_counter #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] occ_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_o <= '0;
    else         occ_o <= occ_o + CNT_W'(inc_i) - CNT_W'(dec_i);
  end
endmodule

// File: rtl/msg_slot_alloc.sv
module msg_slot_alloc
  import msa_pkg::*;
#(
  parameter int unsigned SLOTS = MSA_DEF_SLOTS,
  localparam int unsigned IDX_W = $clog2(SLOTS),
  localparam int unsigned CNT_W = IDX_W + 1,
  localparam int unsigned TX_LO = msa_tx_floor(SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_req_i,
  output logic             rx_gnt_o,
  output logic             rx_fail_o,
  output logic [IDX_W-1:0] rx_idx_o,
  input  logic             tx_req_i,
  output logic             tx_gnt_o,
  output logic             tx_fail_o,
  output logic [IDX_W-1:0] tx_idx_o,
  input  logic             free_i,
  input  logic [IDX_W-1:0] free_idx_i,
  output logic [CNT_W-1:0] occ_o,
  output logic             err_o
);
  logic [SLOTS-1:0] used_q, clr_w, set_w;
  logic [SLOTS-1:0] avail_rx, avail_tx, rx_oh, tx_oh;
  logic             rx_hit, tx_hit, dec_w;

  msa_free_check #(.SLOTS(SLOTS)) u_free (
    .clk_i, .rst_ni, .free_i, .free_idx_i,
    .used_i(used_q), .clr_o(clr_w), .dec_o(dec_w), .err_o
  );

  // a slot freed this cycle is already visible as free
  assign avail_rx = ~used_q | clr_w;

  msa_first_free #(.SLOTS(SLOTS), .BASE(0)) u_rx_find (
    .avail_i(avail_rx), .hit_o(rx_hit), .idx_o(rx_idx_o), .onehot_o(rx_oh)
  );

  assign rx_gnt_o  = rx_req_i & rx_hit;
  assign rx_fail_o = rx_req_i & ~rx_hit;
  assign avail_tx  = avail_rx & ~(rx_gnt_o ? rx_oh : '0);

  msa_first_free #(.SLOTS(SLOTS), .BASE(TX_LO)) u_tx_find (
    .avail_i(avail_tx), .hit_o(tx_hit), .idx_o(tx_idx_o), .onehot_o(tx_oh)
  );

  assign tx_gnt_o  = tx_req_i & tx_hit;
  assign tx_fail_o = tx_req_i & ~tx_hit;
  assign set_w     = (rx_gnt_o ? rx_oh : '0) | (tx_gnt_o ? tx_oh : '0);

  msa_used_bank #(.SLOTS(SLOTS)) u_bank (
    .clk_i, .rst_ni, .set_i(set_w), .clr_i(clr_w), .used_o(used_q)
  );

  msa_occ_counter #(.CNT_W(CNT_W)) u_occ (
    .clk_i, .rst_ni,
    .inc_i({1'b0, rx_gnt_o} + {1'b0, tx_gnt_o}),
    .dec_i(dec_w), .occ_o
  );

  AST_RX_FREE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_gnt_o |-> (!used_q[rx_idx_o] || clr_w[rx_idx_o]));  // R1
  AST_TX_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_gnt_o |-> (int'(tx_idx_o) >= int'(TX_LO)));  // R2
  AST_RX_CLAIMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_gnt_o |=> used_q[$past(rx_idx_o)]);  // R3
  AST_FAIL_XOR_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_gnt_o && rx_fail_o) && !(tx_gnt_o && tx_fail_o)
    && (rx_req_i || !(rx_gnt_o || rx_fail_o)));  // R4
  AST_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_gnt_o && tx_gnt_o) |-> (rx_idx_o != tx_idx_o));  // R6
  AST_OCC_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(occ_o) == $countones(used_q));  // R8
endmodule

// File: tb/msg_slot_alloc_tb.sv
module msg_slot_alloc_tb;
  localparam int SLOTS = 32;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_req_i = 1'b0, tx_req_i = 1'b0, free_i = 1'b0;
  logic [4:0] free_idx_i = '0;
  logic       rx_gnt_o, rx_fail_o, tx_gnt_o, tx_fail_o, err_o;
  logic [4:0] rx_idx_o, tx_idx_o;
  logic [5:0] occ_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  msg_slot_alloc #(.SLOTS(SLOTS)) u_dut (.*);

  typedef struct packed {
    logic       rx; logic tx; logic fr; logic [4:0] fidx;
    logic       erg; logic [4:0] eri;
    logic       etg; logic [4:0] eti;
    logic [5:0] eocc; logic eerr;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,5'd0, 1'b1,5'd0, 1'b0,5'd0, 6'd1,1'b0}, // R1 first rx
    '{1'b0,1'b1,1'b0,5'd0, 1'b0,5'd0, 1'b1,5'd8, 6'd2,1'b0}, // R2 tx at floor
    '{1'b1,1'b1,1'b0,5'd0, 1'b1,5'd1, 1'b1,5'd9, 6'd4,1'b0}, // R6 both
    '{1'b1,1'b0,1'b1,5'd0, 1'b1,5'd0, 1'b0,5'd0, 6'd4,1'b0}, // R7 rx
    '{1'b0,1'b1,1'b1,5'd8, 1'b0,5'd0, 1'b1,5'd8, 6'd4,1'b0}, // R7 tx
    '{1'b1,1'b0,1'b0,5'd0, 1'b1,5'd2, 1'b0,5'd0, 6'd5,1'b0}, // R3 skip used
    '{1'b0,1'b0,1'b1,5'd1, 1'b0,5'd0, 1'b0,5'd0, 6'd4,1'b0}, // R5 free
    '{1'b1,1'b0,1'b0,5'd0, 1'b1,5'd1, 1'b0,5'd0, 6'd5,1'b0}, // R5 reuse
    '{1'b0,1'b0,1'b1,5'd1, 1'b0,5'd0, 1'b0,5'd0, 6'd4,1'b0}, // R5 free
    '{1'b0,1'b0,1'b1,5'd1, 1'b0,5'd0, 1'b0,5'd0, 6'd4,1'b1}, // R9 double
    '{1'b1,1'b0,1'b0,5'd0, 1'b1,5'd1, 1'b0,5'd0, 6'd5,1'b1}  // R9 sticky
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic rx, input logic tx, input logic fr, input int fidx);
    @(negedge clk_i);
    rx_req_i = rx; tx_req_i = tx; free_i = fr; free_idx_i = 5'(fidx);
    #2;
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    #3;
    chk("R10 occ in reset", int'(occ_o), 0);
    chk("R10 err in reset", int'(err_o), 0);
    repeat (2) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].rx, VEC[i].tx, VEC[i].fr, int'(VEC[i].fidx));
      chk("R1 rx grant", int'(rx_gnt_o), int'(VEC[i].erg));
      chk("R4 rx fail", int'(rx_fail_o), int'(VEC[i].rx & ~VEC[i].erg));
      if (VEC[i].erg) chk("R1 rx index", int'(rx_idx_o), int'(VEC[i].eri));
      chk("R2 tx grant", int'(tx_gnt_o), int'(VEC[i].etg));
      chk("R4 tx fail", int'(tx_fail_o), int'(VEC[i].tx & ~VEC[i].etg));
      if (VEC[i].etg) chk("R2 tx index", int'(tx_idx_o), int'(VEC[i].eti));
      tick();
      chk("R8 occupancy", int'(occ_o), int'(VEC[i].eocc));
      chk("R9 error flag", int'(err_o), int'(VEC[i].eerr));
    end

    // used now: 0,1,2,8,9 ; fill transmit range
    for (int k = 10; k < SLOTS; k++) begin
      drive(1'b0, 1'b1, 1'b0, 0);
      chk("R2 tx fill grant", int'(tx_gnt_o), 1);
      chk("R3 tx fill index", int'(tx_idx_o), k);
      tick();
    end
    chk("R8 occ after tx fill", int'(occ_o), 27);
    drive(1'b0, 1'b1, 1'b0, 0);
    chk("R2 tx fail with low slots free", int'(tx_fail_o), 1);
    chk("R4 tx no grant", int'(tx_gnt_o), 0);
    tick();
    chk("R4 occ unchanged on fail", int'(occ_o), 27);

    for (int k = 3; k < 8; k++) begin
      drive(1'b1, 1'b0, 1'b0, 0);
      chk("R1 rx low fill index", int'(rx_idx_o), k);
      tick();
    end
    drive(1'b1, 1'b1, 1'b0, 0);
    chk("R4 rx fail full", int'(rx_fail_o), 1);
    chk("R4 tx fail full", int'(tx_fail_o), 1);
    tick();
    chk("R8 occ full", int'(occ_o), 32);

    drive(1'b0, 1'b1, 1'b1, 31);
    chk("R7 tx takes freed slot", int'(tx_gnt_o), 1);
    chk("R7 tx freed index", int'(tx_idx_o), 31);
    tick();
    chk("R7 occ stays full", int'(occ_o), 32);

    drive(1'b0, 1'b0, 1'b1, 5);
    tick();
    drive(1'b0, 1'b1, 1'b0, 0);
    chk("R2 tx refuses low slot", int'(tx_fail_o), 1);
    tick();
    chk("R5 occ after free", int'(occ_o), 31);
    drive(1'b1, 1'b0, 1'b0, 0);
    chk("R1 rx takes low slot", int'(rx_idx_o), 5);
    tick();

    drive(1'b0, 1'b0, 1'b0, 0);
    rst_ni = 1'b0;
    #2;
    chk("R10 occ on reset", int'(occ_o), 0);
    chk("R10 err on reset", int'(err_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 0);
    chk("R10 rx index after reset", int'(rx_idx_o), 0);
    tick();
    drive(1'b0, 1'b0, 1'b0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule